// File: doc/BRIEF.md
# Permutation Round-Constant Generator

This block supplies one 64-bit round constant per round to an iterated permutation core. The constant is added into a single state word in the last stage of each round. The constants come from a 64-bit linear feedback shift register. The register shifts left, and the new bit enters at bit 0. Its feedback is the XOR of bits 63, 62, 60 and 59, which matches the polynomial x^64 + x^63 + x^61 + x^60 + 1. The register always starts from the hexadecimal seed 0123456789ABCDEF. Sequence entry 0 is the seed itself, and entry n is the value after n shifts.

The permutation core pulses `restart` at the start of a permutation call and raises `step` once per completed round. The constant on `rconst` belongs to the round in progress. A full permutation of 12 rounds uses entries 0 to 11. A short permutation of 6 rounds must use entries 6 to 11. When `short_mode` is high at a restart, the generator first advances six times on its own and lowers `ready` while it does so. The core holds off its first round until `ready` is high. While `step` stays low, the output holds, so the generator stalls together with the core.

The controller has two states. READY is the normal state, where `rconst` is valid. SKIP is the internal pre-advance state. The transitions are:
- any state goes to READY on a restart with `short_mode` low;
- any state goes to SKIP on a restart with `short_mode` high;
- SKIP goes to READY after its sixth advance;
- READY stays in READY on step or idle.

Reset places the block in READY with the seed loaded.

Top module: `rconst_gen`

## Requirements
- R1: After reset, `rconst` equals 0123456789ABCDEF and `ready` is 1.
- R2: In READY, when `step`=1 and `restart`=0, the next cycle's `rconst` is {old[62:0], old[63]^old[62]^old[60]^old[59]}.
- R3: In READY, when `step`=0 and `restart`=0, `rconst` and `ready` keep their values.
- R4: A restart with `short_mode`=0 gives `rconst` = seed and `ready`=1 in the next cycle, whatever the previous state.
- R5: A restart with `short_mode`=1 holds `ready` at 0 for exactly 6 cycles. After that, `ready` is 1 and `rconst` equals sequence entry 6.
- R6: `step` has no effect while `ready` is 0. The value reached at the end of the pre-advance is entry 6 whether `step` was held high or low.
- R7: `restart` takes priority over `step` and over an unfinished pre-advance. A restart in the middle of SKIP starts a fresh 6-cycle pre-advance from the seed.
- R8: After a short-mode restart, five steps bring `rconst` to sequence entry 11, the last constant of the short permutation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Reload the seed and begin a new permutation call |
| step | input | 1 | Advance to the next round's constant |
| short_mode | input | 1 | Sampled at restart: 1 selects the 6-round variant |
| rconst | output | 64 | Round constant for the current round |
| ready | output | 1 | 1 when `rconst` is valid for use |

## Verification
The embedded assertions check four things on every cycle: the shift-and-feedback relation when stepping, the hold when `step` is low, the seed reload after a full-mode restart, and the drop of `ready` after a short-mode restart together with the bound on the skip counter. Some properties only the bench scenarios can show. These are the exact six-cycle length of the pre-advance, the landing on entries 6 and 11, the insensitivity to `step` during SKIP, and a restart cutting a pre-advance short. The bench shows them by comparing against a behavioural polynomial model every cycle and by directed checks at those points.

// File: rtl/rconst_pkg.sv
package rconst_pkg;
    typedef enum logic [0:0] {
        ST_READY = 1'b0,
        ST_SKIP  = 1'b1
    } rc_state_t;
endpackage

// File: rtl/rconst_lfsr.sv
module rconst_lfsr #(
    parameter int          WIDTH    = 64,
    parameter logic [63:0] SEED     = 64'h0123_4567_89AB_CDEF,
    parameter logic [63:0] TAP_MASK = 64'hD800_0000_0000_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    output logic [WIDTH-1:0] value
);
    localparam logic [WIDTH-1:0] SEED_W = SEED[WIDTH-1:0];
    localparam logic [WIDTH-1:0] TAPS_W = TAP_MASK[WIDTH-1:0];

    logic [WIDTH-1:0] q;
    logic             fb;

    // feedback: parity of the tapped bits
    always_comb begin
        fb = ^(q & TAPS_W);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            q <= SEED_W;
        end else if (adv) begin
            q <= {q[WIDTH-2:0], fb};
        end
    end

    assign value = q;
endmodule

// File: rtl/rconst_ctrl.sv
module rconst_ctrl
    import rconst_pkg::*;
#(
    parameter int SKIP_N = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    input  logic short_mode,
    output logic load,
    output logic adv,
    output logic ready
);
    localparam int CW = (SKIP_N > 1) ? $clog2(SKIP_N) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(SKIP_N - 1);

    rc_state_t     state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // next-state decision
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (restart) begin
            state_nx = short_mode ? ST_SKIP : ST_READY;
            cnt_nx   = CNT_LAST;
        end else begin
            unique case (state)
                ST_READY: begin
                    state_nx = ST_READY;
                end
                ST_SKIP: begin
                    if (cnt == '0) begin
                        state_nx = ST_READY;
                    end else begin
                        cnt_nx = cnt - 1'b1;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_READY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        load  = restart;
        adv   = 1'b0;
        ready = 1'b0;
        unique case (state)
            ST_READY: begin
                ready = 1'b1;
                adv   = step && !restart;
            end
            ST_SKIP: begin
                adv   = !restart;
            end
        endcase
    end

    // R5
    skip_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (cnt <= CNT_LAST));

    // R7
    restart_fresh_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && short_mode) |=> (state == ST_SKIP && cnt == CNT_LAST));
endmodule

// File: rtl/rconst_gen.sv
module rconst_gen #(
    parameter int          WIDTH        = 64,
    parameter logic [63:0] SEED         = 64'h0123_4567_89AB_CDEF,
    parameter logic [63:0] TAP_MASK     = 64'hD800_0000_0000_0000,
    parameter int          FULL_ROUNDS  = 12,
    parameter int          SHORT_ROUNDS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic             short_mode,
    output logic [WIDTH-1:0] rconst,
    output logic             ready
);
    localparam int SKIP_N = FULL_ROUNDS - SHORT_ROUNDS;
    localparam logic [WIDTH-1:0] SEED_W = SEED[WIDTH-1:0];
    localparam logic [WIDTH-1:0] TAPS_W = TAP_MASK[WIDTH-1:0];

    logic load, adv;

    rconst_ctrl #(.SKIP_N(SKIP_N)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .step       (step),
        .short_mode (short_mode),
        .load       (load),
        .adv        (adv),
        .ready      (ready)
    );

    rconst_lfsr #(.WIDTH(WIDTH), .SEED(SEED), .TAP_MASK(TAP_MASK)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .adv   (adv),
        .value (rconst)
    );

    // R2
    step_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && step && !restart) |=>
            (rconst == {$past(rconst[WIDTH-2:0]), ^($past(rconst) & TAPS_W)}));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !step && !restart) |=> ($stable(rconst) && ready));

    // R4
    full_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !short_mode) |=> (rconst == SEED_W && ready));

    // R5
    short_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && short_mode) |=> !ready);
endmodule

// File: tb/rconst_gen_bench.sv
module rconst_gen_bench;
    localparam logic [63:0] SEED = 64'h0123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        restart = 1'b0;
    logic        step = 1'b0;
    logic        short_mode = 1'b0;
    logic [63:0] rconst;
    logic        ready;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [63:0] m_val = SEED;
    int          m_skip = 0;

    always #10 clk = ~clk;

    rconst_gen u_rconst_gen (
        .clk(clk), .rst_n(rst_n), .restart(restart), .step(step),
        .short_mode(short_mode), .rconst(rconst), .ready(ready)
    );

    // polynomial x^64+x^63+x^61+x^60+1: term x^e taps bit e-1
    function automatic logic [63:0] next_val(input logic [63:0] v);
        int exps[4] = '{64, 63, 61, 60};
        logic f = 1'b0;
        foreach (exps[i]) f = f ^ v[exps[i]-1];
        return (v << 1) | {63'd0, f};
    endfunction

    function automatic logic [63:0] entry(input int n);
        logic [63:0] v = SEED;
        for (int i = 0; i < n; i++) v = next_val(v);
        return v;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // behavioural reference model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_val = SEED; m_skip = 0;
        end else if (restart) begin
            m_val = SEED; m_skip = short_mode ? 6 : 0;
        end else if (m_skip > 0) begin
            m_val = next_val(m_val); m_skip--;
        end else if (step) begin
            m_val = next_val(m_val);
        end
    end

    // per-cycle comparison (R2 R3 sequence tracking)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model-value", rconst, m_val);
            chk("R3 model-ready", {63'd0, ready}, {63'd0, (m_skip == 0)});
        end
    end

    task automatic tick(); @(negedge clk); endtask

    task automatic do_restart(input logic sm);
        restart = 1'b1; short_mode = sm; tick(); restart = 1'b0;
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1
        chk("R1 seed", rconst, SEED);
        chk("R1 ready", {63'd0, ready}, 64'd1);
        // R2 stepping in full mode
        step = 1'b1; repeat (3) tick(); step = 1'b0;
        chk("R2 entry3", rconst, entry(3));
        // R3 hold
        repeat (4) tick();
        chk("R3 hold", rconst, entry(3));
        // R4 restart full mode from mid sequence
        do_restart(1'b0);
        chk("R4 seed", rconst, SEED);
        chk("R4 ready", {63'd0, ready}, 64'd1);
        step = 1'b1; repeat (11) tick(); step = 1'b0;
        chk("R2 entry11", rconst, entry(11));
        // R5 short restart, step low
        do_restart(1'b1);
        for (int i = 0; i < 6; i++) begin
            chk("R5 ready low", {63'd0, ready}, 64'd0);
            tick();
        end
        chk("R5 ready back", {63'd0, ready}, 64'd1);
        chk("R5 entry6", rconst, entry(6));
        // R8 five steps reach entry 11
        step = 1'b1; repeat (5) tick(); step = 1'b0;
        chk("R8 entry11", rconst, entry(11));
        // R6 step held high through the skip
        step = 1'b1; restart = 1'b1; short_mode = 1'b1; tick(); restart = 1'b0;
        step = 1'b0;
        step = 1'b1; repeat (5) tick(); step = 1'b0;
        tick();
        chk("R6 entry6", rconst, entry(6));
        chk("R6 ready", {63'd0, ready}, 64'd1);
        // R7 restart mid-skip, with step high
        do_restart(1'b1);
        repeat (3) tick();
        step = 1'b1; do_restart(1'b1); step = 1'b0;
        for (int i = 0; i < 6; i++) begin
            chk("R7 ready low", {63'd0, ready}, 64'd0);
            tick();
        end
        chk("R7 entry6", rconst, entry(6));
        // R7 restart beats step in READY
        step = 1'b1; do_restart(1'b0); step = 1'b0;
        chk("R7 seed", rconst, SEED);
        tick();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule